// File: doc/BRIEF.md
# Masked BCD Alarm Comparator

This block is the alarm engine that sits beside a real-time clock. On every half-second tick it compares the running calendar time against a stored alarm stamp. Both are held as BCD fields: half-second phase, seconds, minutes, hours, weekday, day of month and month. A 4-bit interval code decides which of those digits take part in the comparison, so the alarm can fire at intervals from every half second to once a year. When an enabled alarm matches on a tick, the block emits a one-cycle interrupt pulse and flips a square-wave output. The square wave therefore runs at half the alarm rate and stays in the time counter's clock domain.

A repeat counter is loaded by software and decrements on each alarm. When the counter is already zero and chime mode is off, the block issues one final alarm and then clears its own enable. With chime mode on, a zero counter reloads to all ones and the alarm keeps running. The alarm stamp and the interval code can only be written while the alarm is disabled. The repeat count, chime and enable form a separate control write that is always accepted.

Top module: `alarm_unit`

## Requirements
- R1: The interval code picks the compared digits. Each code also compares every digit that a lower code compares, except for the weekday. 1 compares the half-second phase. 2 adds the seconds units digit (bits 3:0). 3 adds the seconds tens digit (bits 7:4). 4 adds the minutes units digit. 5 adds the minutes tens digit. 6 adds both hour digits. 7 adds the weekday. 8 drops the weekday and adds the day of month. 9 adds the month.
- R2: With code 0, every half-second tick seen while enabled is an alarm, whatever the time inputs are.
- R3: An alarm is evaluated only in a cycle where `halfTick` is 1 and the alarm is enabled. `alarmIrq` is 1 for exactly the cycle after that clock edge, once per matching tick.
- R4: Each alarm that is issued with a nonzero repeat count lowers `repeatLeft` by one.
- R5: An alarm issued with `repeatLeft` equal to 0 and chime off is the last one: `armed` reads 0 from the next cycle on, and no further alarms occur.
- R6: An alarm issued with `repeatLeft` equal to 0 and chime on reloads `repeatLeft` to all ones (255 for 8 bits) and leaves `armed` at 1.
- R7: `alarmToggle` changes value in exactly the cycles in which `alarmIrq` is 1, and holds otherwise.
- R8: A write of the alarm stamp and interval code (`valWe`) while `armed` is 1 is ignored. The previous stamp and code keep deciding the matches.
- R9: Interval codes 10 to 15 never produce an alarm.
- R10: A yearly alarm (code 9) stamped for month 02, day 29 fires only when the time inputs show that date. It stays silent on 02/28 and 03/01.
- R11: After reset, `armed`, `repeatLeft`, `alarmIrq` and `alarmToggle` are all 0.
- R12: While `armed` is 0, ticks with matching time produce no alarm and leave `repeatLeft` and `alarmToggle` unchanged.
- R13: A control write (`ctlWe`) loads the repeat count, chime and enable in the same edge. It takes priority over any alarm-driven update of those values in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the time counter domain |
| rstN | input | 1 | Active-low asynchronous reset |
| halfTick | input | 1 | One-cycle pulse at each half-second step of the clock |
| nowHalf | input | 1 | Current half-second phase |
| nowSec | input | 8 | Current seconds, BCD |
| nowMin | input | 8 | Current minutes, BCD |
| nowHour | input | 8 | Current hours, BCD |
| nowWday | input | 3 | Current weekday, 0 to 6 |
| nowDay | input | 8 | Current day of month, BCD |
| nowMon | input | 8 | Current month, BCD |
| valWe | input | 1 | Write strobe for the alarm stamp and interval code |
| setHalf | input | 1 | Alarm half-second phase |
| setSec | input | 8 | Alarm seconds, BCD |
| setMin | input | 8 | Alarm minutes, BCD |
| setHour | input | 8 | Alarm hours, BCD |
| setWday | input | 3 | Alarm weekday |
| setDay | input | 8 | Alarm day of month, BCD |
| setMon | input | 8 | Alarm month, BCD |
| setMask | input | 4 | Interval code |
| ctlWe | input | 1 | Write strobe for repeat count, chime and enable |
| setRepeat | input | CNT_W (8) | Repeat count to load |
| setChime | input | 1 | Chime mode to load |
| setArm | input | 1 | Enable to load |
| alarmIrq | output | 1 | One-cycle alarm interrupt pulse |
| alarmToggle | output | 1 | Square wave that flips on each alarm |
| armed | output | 1 | Current enable state |
| repeatLeft | output | CNT_W (8) | Current repeat count |

## Verification
The embedded properties check several relations on every cycle. An interrupt only follows an enabled tick. The square wave flips exactly with the interrupt. The counter moves down by one, or reloads to all ones in chime mode. A final alarm without chime drops the enable. At most one counter action happens per cycle. The bench scenarios are needed for the parts that depend on stored values and calendar content. These are the digit selection of each interval code, the dead codes 10 to 15, the February 29 yearly case, and writes being ignored while armed. All of them are judged against a reference model that steps alongside the design.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

  localparam int MASK_W     = 4;
  localparam int NUM_GROUPS = 9;
  localparam logic [MASK_W-1:0] LAST_CODE = 4'd9;

  typedef struct packed {
    logic       half;
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [2:0] wday;
    logic [7:0] day;
    logic [7:0] mon;
  } bcdStamp_t;

  typedef struct packed {
    logic loadAlarm;
    logic loadCount;
    logic decCount;
    logic wrapCount;
  } ctlStrobe_t;

  // Whether digit group g takes part in the comparison under interval code.
  function automatic logic groupUsed(input logic [MASK_W-1:0] code, input int g);
    case (g)
      0:       groupUsed = (code >= 4'd1);
      1:       groupUsed = (code >= 4'd2);
      2:       groupUsed = (code >= 4'd3);
      3:       groupUsed = (code >= 4'd4);
      4:       groupUsed = (code >= 4'd5);
      5:       groupUsed = (code >= 4'd6);
      6:       groupUsed = (code == 4'd7);
      7:       groupUsed = (code >= 4'd8);
      8:       groupUsed = (code == 4'd9);
      default: groupUsed = 1'b0;
    endcase
  endfunction

  // Equality of digit group g between the alarm stamp and the time.
  function automatic logic groupEq(input bcdStamp_t a, input bcdStamp_t t, input int g);
    case (g)
      0:       groupEq = (a.half == t.half);
      1:       groupEq = (a.sec[3:0] == t.sec[3:0]);
      2:       groupEq = (a.sec[7:4] == t.sec[7:4]);
      3:       groupEq = (a.min[3:0] == t.min[3:0]);
      4:       groupEq = (a.min[7:4] == t.min[7:4]);
      5:       groupEq = (a.hour == t.hour);
      6:       groupEq = (a.wday == t.wday);
      7:       groupEq = (a.day == t.day);
      8:       groupEq = (a.mon == t.mon);
      default: groupEq = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/alarm_datapath.sv
module alarm_datapath
  import alarm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  bcdStamp_t         nowStamp,
  input  bcdStamp_t         setStamp,
  input  logic [MASK_W-1:0] setMask,
  input  logic [CNT_W-1:0]  setRepeat,
  output logic              matchNow,
  output logic              countZero,
  output logic [CNT_W-1:0]  countQ
);

  localparam logic [CNT_W-1:0] CNT_FULL = '1;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  bcdStamp_t         alarmQ;
  logic [MASK_W-1:0] maskQ;
  logic [CNT_W-1:0]  cntQ;
  logic [NUM_GROUPS-1:0] grpOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alarmQ <= '0;
      maskQ  <= '0;
    end else if (strobe.loadAlarm) begin
      alarmQ <= setStamp;
      maskQ  <= setMask;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 cntQ <= '0;
    else if (strobe.loadCount) cntQ <= setRepeat;
    else if (strobe.wrapCount) cntQ <= CNT_FULL;
    else if (strobe.decCount)  cntQ <= cntQ - CNT_ONE;
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gDigit
    assign grpOk[g] = !groupUsed(maskQ, g) || groupEq(alarmQ, nowStamp, g);
  end

  always_comb begin
    matchNow  = (maskQ <= LAST_CODE) && (&grpOk);
    countZero = (cntQ == '0);
    countQ    = cntQ;
  end

  p_dec_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decCount |=> (cntQ == $past(cntQ) - CNT_ONE));

  p_chime_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrapCount |=> (cntQ == CNT_FULL));

  p_alarm_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadAlarm |=> ($stable(alarmQ) && $stable(maskQ)));

endmodule

// File: rtl/alarm_control.sv
module alarm_control
  import alarm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       halfTick,
  input  logic       matchNow,
  input  logic       countZero,
  input  logic       valWe,
  input  logic       ctlWe,
  input  logic       setChime,
  input  logic       setArm,
  output ctlStrobe_t strobe,
  output logic       alarmIrq,
  output logic       alarmToggle,
  output logic       armed
);

  logic armedQ, chimeQ, irqQ, togQ;
  logic fire, lastShot;

  always_comb begin
    fire     = halfTick && armedQ && matchNow;
    lastShot = fire && countZero && !chimeQ;
    strobe.loadAlarm = valWe && !armedQ;
    strobe.loadCount = ctlWe;
    strobe.decCount  = fire && !ctlWe && !countZero;
    strobe.wrapCount = fire && !ctlWe && countZero && chimeQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedQ <= 1'b0;
      chimeQ <= 1'b0;
      irqQ   <= 1'b0;
      togQ   <= 1'b0;
    end else begin
      irqQ <= fire;
      togQ <= togQ ^ fire;
      if (ctlWe) begin
        armedQ <= setArm;
        chimeQ <= setChime;
      end else if (lastShot) begin
        armedQ <= 1'b0;
      end
    end
  end

  always_comb begin
    alarmIrq    = irqQ;
    alarmToggle = togQ;
    armed       = armedQ;
  end

  p_irq_after_tick_r3: assert property (@(posedge clk) disable iff (!rstN)
    alarmIrq |-> ($past(halfTick) && $past(armedQ)));

  p_toggle_flip_r7: assert property (@(posedge clk) disable iff (!rstN)
    alarmIrq |-> (alarmToggle != $past(alarmToggle)));

  p_toggle_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !alarmIrq |-> $stable(alarmToggle));

  p_last_disarm_r5: assert property (@(posedge clk) disable iff (!rstN)
    (lastShot && !ctlWe) |=> !armedQ);

  p_one_count_action_r13: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadCount, strobe.decCount, strobe.wrapCount}));

endmodule

// File: rtl/alarm_unit.sv
module alarm_unit
  import alarm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             halfTick,
  input  logic             nowHalf,
  input  logic [7:0]       nowSec,
  input  logic [7:0]       nowMin,
  input  logic [7:0]       nowHour,
  input  logic [2:0]       nowWday,
  input  logic [7:0]       nowDay,
  input  logic [7:0]       nowMon,
  input  logic             valWe,
  input  logic             setHalf,
  input  logic [7:0]       setSec,
  input  logic [7:0]       setMin,
  input  logic [7:0]       setHour,
  input  logic [2:0]       setWday,
  input  logic [7:0]       setDay,
  input  logic [7:0]       setMon,
  input  logic [3:0]       setMask,
  input  logic             ctlWe,
  input  logic [CNT_W-1:0] setRepeat,
  input  logic             setChime,
  input  logic             setArm,
  output logic             alarmIrq,
  output logic             alarmToggle,
  output logic             armed,
  output logic [CNT_W-1:0] repeatLeft
);

  bcdStamp_t  nowStamp, setStamp;
  ctlStrobe_t strobe;
  logic       matchNow, countZero;

  always_comb begin
    nowStamp = '{half: nowHalf, sec: nowSec, min: nowMin, hour: nowHour,
                 wday: nowWday, day: nowDay, mon: nowMon};
    setStamp = '{half: setHalf, sec: setSec, min: setMin, hour: setHour,
                 wday: setWday, day: setDay, mon: setMon};
  end

  alarm_control i_control (
    .clk         (clk),
    .rstN        (rstN),
    .halfTick    (halfTick),
    .matchNow    (matchNow),
    .countZero   (countZero),
    .valWe       (valWe),
    .ctlWe       (ctlWe),
    .setChime    (setChime),
    .setArm      (setArm),
    .strobe      (strobe),
    .alarmIrq    (alarmIrq),
    .alarmToggle (alarmToggle),
    .armed       (armed)
  );

  alarm_datapath #(.CNT_W(CNT_W)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .nowStamp  (nowStamp),
    .setStamp  (setStamp),
    .setMask   (setMask),
    .setRepeat (setRepeat),
    .matchNow  (matchNow),
    .countZero (countZero),
    .countQ    (repeatLeft)
  );

endmodule

// File: tb/test_alarm_unit.sv
`timescale 1ns/1ps
module test_alarm_unit;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic halfTick = 1'b0;
  logic [43:0] nowV = '0;   // {half, sec, min, hour, wday, day, mon}
  logic [43:0] setV = '0;
  logic valWe = 1'b0, ctlWe = 1'b0, setChime = 1'b0, setArm = 1'b0;
  logic [3:0] setMask = '0;
  logic [7:0] setRepeat = '0;
  logic alarmIrq, alarmToggle, armed;
  logic [7:0] repeatLeft;

  int nChecks = 0;
  int nFails  = 0;

  // reference model state
  logic mArmed = 0, mChime = 0, mTog = 0, mIrq = 0;
  logic [7:0] mCnt = 0;
  logic [3:0] mMask = 0;
  logic [43:0] mAlarm = '0;

  always #2 clk = ~clk;

  alarm_unit i_alarm_unit (
    .clk(clk), .rstN(rstN), .halfTick(halfTick),
    .nowHalf(nowV[43]), .nowSec(nowV[42:35]), .nowMin(nowV[34:27]),
    .nowHour(nowV[26:19]), .nowWday(nowV[18:16]), .nowDay(nowV[15:8]), .nowMon(nowV[7:0]),
    .valWe(valWe),
    .setHalf(setV[43]), .setSec(setV[42:35]), .setMin(setV[34:27]),
    .setHour(setV[26:19]), .setWday(setV[18:16]), .setDay(setV[15:8]), .setMon(setV[7:0]),
    .setMask(setMask), .ctlWe(ctlWe), .setRepeat(setRepeat), .setChime(setChime),
    .setArm(setArm), .alarmIrq(alarmIrq), .alarmToggle(alarmToggle), .armed(armed),
    .repeatLeft(repeatLeft)
  );

  function automatic logic refMatch(input logic [3:0] c, input logic [43:0] a, input logic [43:0] t);
    logic h, su, st, mu, mt, hr, wd, dy, mo;
    h  = a[43] == t[43];
    su = a[38:35] == t[38:35];
    st = a[42:39] == t[42:39];
    mu = a[30:27] == t[30:27];
    mt = a[34:31] == t[34:31];
    hr = a[26:19] == t[26:19];
    wd = a[18:16] == t[18:16];
    dy = a[15:8] == t[15:8];
    mo = a[7:0] == t[7:0];
    case (c)
      4'd0: refMatch = 1'b1;
      4'd1: refMatch = h;
      4'd2: refMatch = h && su;
      4'd3: refMatch = h && su && st;
      4'd4: refMatch = h && su && st && mu;
      4'd5: refMatch = h && su && st && mu && mt;
      4'd6: refMatch = h && su && st && mu && mt && hr;
      4'd7: refMatch = h && su && st && mu && mt && hr && wd;
      4'd8: refMatch = h && su && st && mu && mt && hr && dy;
      4'd9: refMatch = h && su && st && mu && mt && hr && dy && mo;
      default: refMatch = 1'b0;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one clock: predict, step, compare at negedge, release strobes
  task automatic cyc();
    logic fire;
    fire = halfTick && mArmed && refMatch(mMask, mAlarm, nowV);
    if (valWe && !mArmed) begin
      mAlarm = setV;
      mMask  = setMask;
    end
    mIrq = fire;
    mTog = mTog ^ fire;
    if (fire) begin
      if (mCnt != 0) mCnt = mCnt - 8'd1;
      else if (mChime) mCnt = 8'hFF;
      else mArmed = 1'b0;
    end
    if (ctlWe) begin
      mCnt = setRepeat; mChime = setChime; mArmed = setArm;
    end
    @(posedge clk);
    @(negedge clk);
    check("R3 irq", alarmIrq, mIrq);
    check("R7 toggle", alarmToggle, mTog);
    check("R5 armed", armed, mArmed);
    check("R4 count", repeatLeft, mCnt);
    halfTick = 0; valWe = 0; ctlWe = 0;
  endtask

  task automatic ctlWrite(input logic [7:0] cnt, input logic ch, input logic arm);
    ctlWe = 1; setRepeat = cnt; setChime = ch; setArm = arm;
    cyc();
  endtask

  task automatic configure(input logic [43:0] a, input logic [3:0] code,
                           input logic [7:0] cnt, input logic ch);
    ctlWrite(8'd0, 1'b0, 1'b0);
    valWe = 1; setV = a; setMask = code;
    cyc();
    ctlWrite(cnt, ch, 1'b1);
  endtask

  task automatic tickAt(input logic [43:0] t);
    nowV = t; halfTick = 1;
    cyc();
  endtask

  function automatic logic [7:0] rndBcd(input int tensMax);
    rndBcd = {4'($urandom_range(tensMax, 0)), 4'($urandom_range(9, 0))};
  endfunction

  function automatic logic [43:0] rndStamp();
    rndStamp = {1'($urandom_range(1, 0)), rndBcd(5), rndBcd(5), rndBcd(2),
                3'($urandom_range(6, 0)), rndBcd(3), rndBcd(1)};
  endfunction

  initial begin
    #(4 * 150000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [43:0] a, t;
    int irqs;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 armed", armed, 0);
    check("R11 count", repeatLeft, 0);
    check("R11 irq", alarmIrq, 0);
    check("R11 toggle", alarmToggle, 0);
    rstN = 1;
    @(negedge clk);

    // R12 disarmed: matching ticks do nothing
    tickAt(44'h0);
    check("R12 no irq while disarmed", alarmIrq, 0);

    // R2 code 0 fires every tick; count 5 -> 2 after three
    configure(44'h0, 4'd0, 8'd5, 1'b0);
    irqs = 0;
    for (int i = 0; i < 3; i++) begin
      tickAt(rndStamp());
      irqs += alarmIrq;
    end
    check("R2 every tick fires", irqs, 3);
    check("R4 count after three", repeatLeft, 2);

    // R8 write while armed is ignored: code 10 would never fire
    valWe = 1; setMask = 4'd10; setV = 44'h0;
    cyc();
    tickAt(rndStamp());
    check("R8 old code still fires", alarmIrq, 1);

    // R5 zero count, no chime: one alarm then disarm
    ctlWrite(8'd0, 1'b0, 1'b1);
    tickAt(rndStamp());
    check("R5 last alarm", alarmIrq, 1);
    check("R5 disarmed", armed, 0);
    tickAt(rndStamp());
    check("R5 no alarm after last", alarmIrq, 0);

    // R6 chime wraps to FF
    ctlWrite(8'd0, 1'b1, 1'b1);
    tickAt(rndStamp());
    check("R6 count wraps", repeatLeft, 255);
    check("R6 stays armed", armed, 1);

    // R13 control write wins over alarm update in same cycle
    ctlWe = 1; setRepeat = 8'd7; setChime = 1'b0; setArm = 1'b1;
    halfTick = 1;
    cyc();
    check("R13 load wins", repeatLeft, 7);

    // R1 minute code: seconds digits and half decide
    a = 44'h0; a[42:35] = 8'h30;
    configure(a, 4'd3, 8'd9, 1'b0);
    t = rndStamp(); t[43] = 1'b0; t[42:35] = 8'h30;
    tickAt(t);
    check("R1 minute code match", alarmIrq, 1);
    t[42:35] = 8'h31;
    tickAt(t);
    check("R1 minute code units differ", alarmIrq, 0);

    // R9 dead code
    configure(44'h0, 4'd12, 8'd3, 1'b0);
    tickAt(44'h0);
    check("R9 code 12 silent", alarmIrq, 0);

    // R10 yearly Feb 29
    a = 44'h0; a[26:19] = 8'h12; a[15:8] = 8'h29; a[7:0] = 8'h02;
    configure(a, 4'd9, 8'd4, 1'b0);
    t = a; t[15:8] = 8'h28;
    tickAt(t);
    check("R10 silent on 02/28", alarmIrq, 0);
    t[15:8] = 8'h01; t[7:0] = 8'h03;
    tickAt(t);
    check("R10 silent on 03/01", alarmIrq, 0);
    tickAt(a);
    check("R10 fires on 02/29", alarmIrq, 1);

    // R1 R3 random mix of codes, stamps and ticks
    for (int k = 0; k < 40; k++) begin
      a = rndStamp();
      configure(a, 4'($urandom_range(11, 0)), 8'($urandom_range(6, 0)), 1'($urandom_range(1, 0)));
      for (int n = 0; n < 150; n++) begin
        t = a;
        if ($urandom_range(2, 0) == 0) t[43] = ~t[43];
        if ($urandom_range(3, 0) == 0) t[42:35] = rndBcd(5);
        if ($urandom_range(3, 0) == 0) t[34:27] = rndBcd(5);
        if ($urandom_range(4, 0) == 0) t[26:19] = rndBcd(2);
        if ($urandom_range(4, 0) == 0) t[18:16] = 3'($urandom_range(6, 0));
        if ($urandom_range(4, 0) == 0) t[15:8] = rndBcd(3);
        if ($urandom_range(4, 0) == 0) t[7:0] = rndBcd(1);
        nowV = t;
        halfTick = 1'($urandom_range(1, 0));
        cyc();
      end
    end

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule